// File: doc/BRIEF.md
# Prioritized Restart Interrupt Arbiter

This block decides which of five interrupt sources an 8-bit processor core should service next. The sources are a non-maskable trap line, three ranked restart lines (high, middle and low) and one general request line. The block holds a global interrupt-enable flag and a mask bit for each restart line. It presents a single request to the core, and when the core signals an instruction boundary it records the winning source and its restart vector.

The trap line is accepted only if a rising edge has been seen and the line is still high. The high restart line is edge-captured and stays pending until it is serviced or cleared by software. The middle and low lines are level-sensitive. When the general line wins, the block pulses an acknowledge output. While that pulse is high the core holds its program counter and fetches the vectoring instruction from its own data bus. The block's vector output reads zero for that source.

A status word shows the three masks, the enable flag and the raw pending state of the three restart lines. The core can read it at any time.

Top module: `rst_intr_arbiter`

## Requirements
- R1: After reset the enable flag is 0, all three masks are 1, src_id is 0, vector is 0x00, inta is 0 and irq_req is 0.
- R2: The trap source ignores the enable flag and the masks. A rising edge on trap_in is captured one clock later, and the trap is requested only while that capture is set and trap_in is still high. Servicing clears the capture, so a trap held high does not request again. The trap's src_id is 1 and its vector is 0x24.
- R3: Fixed priority is trap > high (src_id 2, vector 0x3C) > middle (src_id 3, vector 0x34) > low (src_id 4, vector 0x2C) > general (src_id 5, vector 0x00).
- R4: The restart and general sources can win only while the enable flag is 1. A restart source also needs its mask bit to be 0.
- R5: A rising edge on rq_hi sets a pending flag that stays set after the line falls. The flag is cleared when the high source is serviced, or by a mask write with bit 4 = 1.
- R6: rq_mid and rq_lo are level-sensitive. Lowering the line withdraws its request.
- R7: A mask write updates the masks only when mask_data bit 3 is 1. Bits 2, 1 and 0 are then the masks of high, middle and low.
- R8: Sources are evaluated only on a clock edge where take is 1 and irq_req is 1. That edge loads src_id and vector and clears the enable flag. Without take, src_id and vector hold.
- R9: When the general source is accepted, inta is 1 for exactly the next cycle. Accepting any other source leaves inta at 0.
- R10: status bit 6 is the high pending flag, bit 5 is rq_mid, bit 4 is rq_lo, bit 3 is the enable flag, and bits 2:0 are the masks of high, middle and low.
- R11: ie_set sets the enable flag and ie_clr clears it. When both are 1, ie_clr wins. Accepting an interrupt on the same edge overrides both and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_in | input | 1 | Non-maskable trap request |
| rq_hi | input | 1 | Highest restart request, edge-captured |
| rq_mid | input | 1 | Middle restart request, level |
| rq_lo | input | 1 | Lowest restart request, level |
| gen_req | input | 1 | General interrupt request |
| ie_set | input | 1 | Set the enable flag |
| ie_clr | input | 1 | Clear the enable flag |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 5 | Mask write data: [4] clear high pending, [3] update masks, [2:0] masks |
| take | input | 1 | Instruction-boundary strobe from the core |
| irq_req | output | 1 | A source is eligible for service |
| src_id | output | 3 | Last accepted source |
| vector | output | 8 | Restart vector of the last accepted source |
| inta | output | 1 | One-cycle acknowledge for the general source |
| status | output | 7 | Masks, enable flag and pending state |

## Verification
The embedded properties check on every cycle that:
- an accept clears the enable flag;
- src_id holds when take is low;
- masks change only under an enabled write;
- the high pending flag survives until a clearing event;
- a live trap always raises irq_req;
- inta never lasts two cycles.

The ranking between simultaneous sources, the trap's edge-and-level rule and the correct vector for each winner are shown only by the bench's scenarios, together with a cycle-by-cycle reference model.

// File: rtl/rst_intr_arbiter.sv
module rst_intr_arbiter #(
  parameter logic [7:0] VEC_TRAP = 8'h24,
  parameter logic [7:0] VEC_HI   = 8'h3C,
  parameter logic [7:0] VEC_MID  = 8'h34,
  parameter logic [7:0] VEC_LO   = 8'h2C,
  parameter int         SRC_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             rq_hi,
  input  logic             rq_mid,
  input  logic             rq_lo,
  input  logic             gen_req,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             mask_wr,
  input  logic [4:0]       mask_data,
  input  logic             take,
  output logic             irq_req,
  output logic [SRC_W-1:0] src_id,
  output logic [7:0]       vector,
  output logic             inta,
  output logic [6:0]       status
);
  localparam logic [SRC_W-1:0] S_NONE = SRC_W'(0);
  localparam logic [SRC_W-1:0] S_TRAP = SRC_W'(1);
  localparam logic [SRC_W-1:0] S_HI   = SRC_W'(2);
  localparam logic [SRC_W-1:0] S_MID  = SRC_W'(3);
  localparam logic [SRC_W-1:0] S_LO   = SRC_W'(4);
  localparam logic [SRC_W-1:0] S_GEN  = SRC_W'(5);

  logic             ie, hi_pend, trap_cap, trap_d, hi_d;
  logic [2:0]       msk;
  logic [SRC_W-1:0] win;
  logic [7:0]       win_vec;

  wire trap_live = trap_cap & trap_in;
  wire accept    = take & irq_req;
  wire msk_upd   = mask_wr & mask_data[3];
  wire hi_wipe   = mask_wr & mask_data[4];

  always_comb begin
    win = S_NONE;
    win_vec = 8'h00;
    if (trap_live) begin
      win = S_TRAP; win_vec = VEC_TRAP;
    end else if (ie && hi_pend && !msk[2]) begin
      win = S_HI; win_vec = VEC_HI;
    end else if (ie && rq_mid && !msk[1]) begin
      win = S_MID; win_vec = VEC_MID;
    end else if (ie && rq_lo && !msk[0]) begin
      win = S_LO; win_vec = VEC_LO;
    end else if (ie && gen_req) begin
      win = S_GEN;
    end
  end

  assign irq_req = (win != S_NONE);
  assign status  = {hi_pend, rq_mid, rq_lo, ie, msk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie       <= 1'b0;
      msk      <= 3'b111;
      hi_pend  <= 1'b0;
      trap_cap <= 1'b0;
      trap_d   <= 1'b0;
      hi_d     <= 1'b0;
      src_id   <= S_NONE;
      vector   <= 8'h00;
      inta     <= 1'b0;
    end else begin
      trap_d <= trap_in;
      hi_d   <= rq_hi;
      inta   <= accept && (win == S_GEN);
      if (accept) begin
        src_id <= win;
        vector <= win_vec;
      end
      if (accept)      ie <= 1'b0;
      else if (ie_clr) ie <= 1'b0;
      else if (ie_set) ie <= 1'b1;
      if (msk_upd) msk <= mask_data[2:0];
      if ((accept && win == S_HI) || hi_wipe) hi_pend <= 1'b0;
      else if (rq_hi && !hi_d)                hi_pend <= 1'b1;
      if (accept && win == S_TRAP)   trap_cap <= 1'b0;
      else if (trap_in && !trap_d)   trap_cap <= 1'b1;
    end
  end

  AST_ACCEPT_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !status[3]); // R8
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(src_id) && $stable(vector))); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_upd |=> $stable(status[2:0])); // R7
  AST_HI_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !take && !hi_wipe) |=> status[6]); // R5
  AST_TRAP_NOMASK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_live |-> irq_req); // R2
  AST_INTA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> !inta); // R9
  AST_INTA_GEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> (src_id == S_GEN)); // R9
endmodule

// File: tb/rst_intr_arbiter_test.sv
`timescale 1ns/100ps
module rst_intr_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic trap_in = 0, rq_hi = 0, rq_mid = 0, rq_lo = 0, gen_req = 0;
  logic ie_set = 0, ie_clr = 0, mask_wr = 0, take = 0;
  logic [4:0] mask_data = 0;
  logic irq_req, inta;
  logic [2:0] src_id;
  logic [7:0] vector;
  logic [6:0] status;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  rst_intr_arbiter uut (.clk, .rst_n, .trap_in, .rq_hi, .rq_mid, .rq_lo, .gen_req,
    .ie_set, .ie_clr, .mask_wr, .mask_data, .take, .irq_req, .src_id, .vector,
    .inta, .status);

  // behavioural reference model
  bit m_ie, m_p75, m_trl, m_ptr, m_phi, m_inta;
  bit [2:0] m_msk;
  int m_src;
  int m_vec;

  function automatic int pick();
    if (m_trl && trap_in) return 1;
    if (!m_ie) return 0;
    if (m_p75 && !m_msk[2]) return 2;
    if (rq_mid && !m_msk[1]) return 3;
    if (rq_lo && !m_msk[0]) return 4;
    if (gen_req) return 5;
    return 0;
  endfunction

  function automatic int vec_of(int s);
    case (s)
      1: return 'h24;
      2: return 'h3C;
      3: return 'h34;
      4: return 'h2C;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int w;
    bit acc;
    if (!rst_n) begin
      m_ie = 0; m_msk = 3'b111; m_p75 = 0; m_trl = 0; m_ptr = 0; m_phi = 0;
      m_src = 0; m_vec = 0; m_inta = 0;
    end else begin
      w = pick();
      acc = take && (w != 0);
      m_inta = acc && (w == 5);
      if (acc) begin m_src = w; m_vec = vec_of(w); end
      if (acc) m_ie = 0; else if (ie_clr) m_ie = 0; else if (ie_set) m_ie = 1;
      if (mask_wr && mask_data[3]) m_msk = mask_data[2:0];
      if ((acc && w == 2) || (mask_wr && mask_data[4])) m_p75 = 0;
      else if (rq_hi && !m_phi) m_p75 = 1;
      if (acc && w == 1) m_trl = 0; else if (trap_in && !m_ptr) m_trl = 1;
      m_phi = rq_hi; m_ptr = trap_in;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R4 model irq_req", int'(irq_req), int'(pick() != 0));
    chk("R3 model src_id", int'(src_id), m_src);
    chk("R3 model vector", int'(vector), m_vec);
    chk("R9 model inta", int'(inta), int'(m_inta));
    chk("R10 model status", int'(status), int'({m_p75, rq_mid, rq_lo, m_ie, m_msk}));
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); #0.5; endtask
  task automatic en(); ie_set = 1; tick(); ie_set = 0; settle(); endtask
  task automatic mwr(logic [4:0] d);
    mask_wr = 1; mask_data = d; tick(); mask_wr = 0; mask_data = 0; settle();
  endtask
  task automatic tk(); take = 1; tick(); take = 0; settle(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; settle();
    chk("R1 src", src_id, 0); chk("R1 vec", vector, 0); chk("R1 inta", inta, 0);
    chk("R1 irq", irq_req, 0); chk("R1 status", status, 7'h07);

    en(); chk("R11 set", status[3], 1);
    ie_set = 1; ie_clr = 1; tick(); ie_set = 0; ie_clr = 0; settle();
    chk("R11 clr wins", status[3], 0);
    en();
    mwr(5'b00000); chk("R7 no update", status[2:0], 3'b111);
    mwr(5'b01000); chk("R7 update", status[2:0], 3'b000);

    rq_mid = 1; rq_lo = 1; settle();
    chk("R10 levels", status[5:4], 2'b11); chk("R6 request", irq_req, 1);
    tick(); tick(); settle(); chk("R8 no take", src_id, 0);
    tk();
    chk("R3 mid", src_id, 3); chk("R3 mid vec", vector, 8'h34);
    chk("R9 no inta", inta, 0); chk("R8 ie cleared", status[3], 0);
    chk("R4 ie gate", irq_req, 0);
    rq_mid = 0; en(); chk("R6 lo still", irq_req, 1);
    rq_lo = 0; settle(); chk("R6 level drop", irq_req, 0);

    rq_hi = 1; tick(); rq_hi = 0; settle(); chk("R5 captured", status[6], 1);
    tick(); tick(); settle(); chk("R5 held", status[6], 1); chk("R5 req", irq_req, 1);
    rq_lo = 1; gen_req = 1; tk();
    chk("R3 hi", src_id, 2); chk("R3 hi vec", vector, 8'h3C); chk("R5 serviced", status[6], 0);
    en(); tk(); chk("R3 lo", src_id, 4); chk("R3 lo vec", vector, 8'h2C);
    rq_lo = 0; en(); tk();
    chk("R3 gen", src_id, 5); chk("R3 gen vec", vector, 0); chk("R9 inta", inta, 1);
    tick(); settle(); chk("R9 inta ends", inta, 0);
    gen_req = 0;

    en(); mwr(5'b01111); rq_lo = 1; rq_mid = 1; settle();
    chk("R4 masked", irq_req, 0);
    rq_hi = 1; tick(); rq_hi = 0; settle();
    chk("R4 hi masked", irq_req, 0); chk("R5 pend", status[6], 1);
    mwr(5'b10000); chk("R5 wipe", status[6], 0); chk("R7 kept", status[2:0], 3'b111);
    mwr(5'b01000); chk("R4 unmasked", irq_req, 1);
    ie_clr = 1; tick(); ie_clr = 0; settle(); chk("R4 ie off", irq_req, 0);
    rq_mid = 0; rq_lo = 0; gen_req = 1; settle(); chk("R4 gen gated", irq_req, 0);
    gen_req = 0;

    trap_in = 1; tick(); settle(); chk("R2 trap no ie", irq_req, 1);
    tk(); chk("R2 src", src_id, 1); chk("R2 vec", vector, 8'h24);
    chk("R2 no retrigger", irq_req, 0);
    trap_in = 0; tick();
    trap_in = 1; tick(); trap_in = 0; settle(); chk("R2 needs level", irq_req, 0);
    en(); rq_hi = 1; trap_in = 1; tick(); rq_hi = 0; settle();
    chk("R2 live", irq_req, 1);
    tk(); chk("R3 trap over hi", src_id, 1);
    trap_in = 0; en(); tk(); chk("R3 hi after trap", src_id, 2);
    tick(); tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule